// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Counter

This block is a 32-bit up-counting timer core for use behind a simple register-write port. A free-running prescaler can slow the counter to one step every 2, 4, up to 256 clock cycles. Without the prescaler, the counter steps once per clock while running. When the counter steps past all-ones it raises a one-cycle overflow pulse. It then either reloads from a programmable reload register and keeps counting, or, in one-shot mode, wraps to zero and stops itself. A compare register, gated by a compare-enable bit, raises a one-cycle match pulse when the counter steps onto its value.

Software controls the block with single-cycle writes. A write can set the control bits or load the counter directly. It can also update the reload or compare registers, or strike a trigger address that reloads the counter from the reload register. Starting, stopping, direct loads, trigger writes and auto-reload overflows each restart the prescaler phase. The next counter step after any of these events therefore comes a full division period later.

Top module: `ptimer_top`

## Requirements
- R1: A write with `wr_en` high takes effect at that clock edge. The address map is: 0 control, 1 counter, 2 reload, 3 compare, 4 trigger. The trigger write ignores its data. The control bits are: bit 0 run, bit 1 auto-reload, bit 2 prescaler enable, bits 5:3 ratio, bit 6 compare enable. `run_o` shows the run bit.
- R2: After reset, the counter, both pulses and `run_o` are zero. A counter write sets `count_o` to the written data at the next edge, and the counter keeps that value while stopped.
- R3: While running with the prescaler disabled, `count_o` rises by one at every clock edge, starting at the edge after the run bit is written.
- R4: With the prescaler enabled and ratio n, the counter steps once every 2^(n+1) clock edges. The first step comes 2^(n+1) edges after the run bit is written.
- R5: A counter write or a trigger write restarts the prescaler phase. The next step comes 2^(n+1) edges after the write.
- R6: A trigger write loads `count_o` with the reload register value at the next edge.
- R7: Clearing the run bit freezes `count_o` and resets the prescaler phase. After a restart, the first step comes a full 2^(n+1) edges later.
- R8: With auto-reload on, a step from all-ones loads the reload value and raises `ovf_o` for exactly one cycle, in the cycle that first shows the reloaded value. The overflow period is (0xFFFFFFFF − reload + 1) steps.
- R9: With auto-reload off, a step from all-ones wraps `count_o` to zero, raises `ovf_o` for one cycle and clears the run bit. The counter then stays at zero.
- R10: With compare enable set, `match_o` is high for exactly one cycle, in the cycle in which a counter step makes `count_o` equal the compare register. With compare enable clear, `match_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| count_o | output | 32 | Current counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| match_o | output | 1 | One-cycle compare match pulse |
| run_o | output | 1 | Run bit of the control register |

## Verification
The single-cycle overflow property assumes the reload value is at least one below all-ones, so that two overflows can never fall in adjacent cycles. The stimulus keeps the reload and compare values at least two below all-ones. It also writes only the five defined addresses. When a test depends on a quiet counter, it issues no counter or trigger write in the same cycle as the step it checks.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int RATIO_W = 3;
  localparam int ADDR_W  = 3;

  typedef struct packed {
    logic               cmp_en;
    logic [RATIO_W-1:0] ratio;
    logic               pre_en;
    logic               auto_rld;
    logic               run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_RELOAD = 3'd2,
    REG_CMP    = 3'd3,
    REG_TRIG   = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              oneshot_stop,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  cmp,
  output logic              cnt_load,
  output logic              trig_load
);

  logic ctrl_wr, rld_wr, cmp_wr;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
    cnt_load  = wr_en && (wr_addr == REG_COUNT);
    rld_wr    = wr_en && (wr_addr == REG_RELOAD);
    cmp_wr    = wr_en && (wr_addr == REG_CMP);
    trig_load = wr_en && (wr_addr == REG_TRIG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
      cmp    <= '0;
    end else begin
      if (ctrl_wr)
        ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (oneshot_stop)
        ctrl.run <= 1'b0;
      if (rld_wr)
        reload <= wr_data;
      if (cmp_wr)
        cmp <= wr_data;
    end
  end

  AST_ONESHOT_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (oneshot_stop && !ctrl_wr) |=> !ctrl.run); // R9

  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl.run == $past(wr_data[0]))); // R1

endmodule

// File: rtl/ptimer_presc.sv
module ptimer_presc
  import ptimer_pkg::*;
#(
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               pre_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clr,
  output logic               tick
);

  generate
    if (HAS_PRESC) begin : g_presc
      localparam int PC_W = 1 << RATIO_W;
      logic [PC_W-1:0] pcnt_q;
      logic [PC_W-1:0] limit;

      always_comb begin
        limit = {PC_W{1'b1}} >> ((PC_W - 1) - int'(ratio));
        tick  = run && (!pre_en || (pcnt_q == limit));
      end

      always_ff @(posedge clk) begin
        if (rst || clr || !run || !pre_en || tick)
          pcnt_q <= '0;
        else
          pcnt_q <= pcnt_q + 1'b1;
      end

      AST_PRESC_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt_q == '0)); // R7

      AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pcnt_q == '0)); // R5
    end else begin : g_direct
      always_comb tick = run;
    end
  endgenerate

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick); // R7

endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             auto_rld,
  input  logic             cmp_en,
  input  logic             cnt_load,
  input  logic             trig_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             match_q,
  output logic             oneshot_stop,
  output logic             rld_wrap
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic             sw_write;
  logic             at_top;
  logic             wrap;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    sw_write     = cnt_load || trig_load;
    at_top       = (count_q == TOP);
    wrap         = tick && at_top && !sw_write;
    nxt          = at_top ? (auto_rld ? reload : '0) : count_q + 1'b1;
    oneshot_stop = wrap && !auto_rld;
    rld_wrap     = wrap && auto_rld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ovf_q   <= wrap;
      match_q <= tick && !sw_write && cmp_en && (nxt == cmp);
      if (cnt_load)
        count_q <= load_val;
      else if (trig_load)
        count_q <= reload;
      else if (tick)
        count_q <= nxt;
    end
  end

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q); // R8

  AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && $past(auto_rld)) |-> (count_q == $past(reload))); // R8

  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !$past(auto_rld)) |-> (count_q == '0)); // R9

  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (rst)
    match_q |-> ($past(cmp_en) && count_q == $past(cmp))); // R10

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> (count_q == $past(load_val))); // R2

  AST_TRIG_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (trig_load && !cnt_load) |=> (count_q == $past(reload))); // R6

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic              match_o,
  output logic              run_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cmp;
  logic             cnt_load, trig_load;
  logic             oneshot_stop, rld_wrap;
  logic             tick, presc_clr;

  ptimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .oneshot_stop (oneshot_stop),
    .ctrl         (ctrl),
    .reload       (reload),
    .cmp          (cmp),
    .cnt_load     (cnt_load),
    .trig_load    (trig_load)
  );

  always_comb presc_clr = cnt_load || trig_load || rld_wrap;

  ptimer_presc #(.HAS_PRESC(HAS_PRESC)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl.run),
    .pre_en (ctrl.pre_en),
    .ratio  (ctrl.ratio),
    .clr    (presc_clr),
    .tick   (tick)
  );

  ptimer_count #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .auto_rld     (ctrl.auto_rld),
    .cmp_en       (ctrl.cmp_en),
    .cnt_load     (cnt_load),
    .trig_load    (trig_load),
    .load_val     (wr_data),
    .reload       (reload),
    .cmp          (cmp),
    .count_q      (count_o),
    .ovf_q        (ovf_o),
    .match_q      (match_o),
    .oneshot_stop (oneshot_stop),
    .rld_wrap     (rld_wrap)
  );

  always_comb run_o = ctrl.run;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !cnt_load && !trig_load) |=> (count_o == $past(count_o))); // R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_load && !trig_load && count_o != '1) |=> (count_o == $past(count_o) + 1'b1)); // R3

endmodule

// File: tb/test_ptimer_top.sv
module test_ptimer_top;

  localparam logic [31:0] MAX = 32'hFFFF_FFFF;
  localparam logic [31:0] C_RUN = 32'h01, C_AR = 32'h02, C_PRE = 32'h04, C_CE = 32'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        ovf_o, match_o, run_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptimer_top i_ptimer_top (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_o (count_o),
    .ovf_o   (ovf_o),
    .match_o (match_o),
    .run_o   (run_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    step(1);
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    check("R2 reset count", count_o, 0);
    check("R2 reset ovf", {31'd0, ovf_o}, 0);
    check("R2 reset match", {31'd0, match_o}, 0);
    check("R2 reset run", {31'd0, run_o}, 0);
  endtask

  task automatic t_load_and_count();
    wr(3'd1, 32'd100);
    check("R2 load", count_o, 100);
    step(4);
    check("R2 hold while stopped", count_o, 100);
    wr(3'd0, C_RUN);
    check("R1 run bit", {31'd0, run_o}, 1);
    for (int k = 0; k <= 5; k++) begin
      check("R3 count per cycle", count_o, 100 + k);
      step(1);
    end
    wr(3'd0, 32'd0);
    check("R1 run bit cleared", {31'd0, run_o}, 0);
  endtask

  task automatic t_prescale();
    wr(3'd1, 32'd0);
    wr(3'd0, C_RUN | C_PRE | (32'd1 << 3));
    for (int k = 0; k <= 12; k++) begin
      check("R4 divide by 4", count_o, k / 4);
      step(1);
    end
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, C_RUN | C_PRE);
    for (int k = 0; k <= 8; k++) begin
      check("R4 divide by 2", count_o, k / 2);
      step(1);
    end
  endtask

  task automatic t_presc_restart();
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd200);
    wr(3'd0, C_RUN | C_PRE | (32'd2 << 3));
    step(3);
    wr(3'd1, 32'd50);
    for (int k = 0; k <= 8; k++) begin
      check("R5 phase restart on counter write", count_o, 50 + ((k >= 8) ? 1 : 0));
      step(1);
    end
    step(5);
    wr(3'd4, 32'h1234);
    check("R6 trigger reload", count_o, 200);
    for (int k = 0; k <= 8; k++) begin
      check("R5 phase restart on trigger", count_o, 200 + ((k >= 8) ? 1 : 0));
      step(1);
    end
  endtask

  task automatic t_stop();
    logic [31:0] c;
    wr(3'd0, C_RUN | C_PRE | (32'd2 << 3));
    step(5);
    wr(3'd0, 32'd0);
    c = count_o;
    for (int k = 0; k < 10; k++) begin
      step(1);
      check("R7 frozen while stopped", count_o, c);
    end
    wr(3'd0, C_RUN | C_PRE | (32'd2 << 3));
    for (int k = 0; k <= 8; k++) begin
      check("R7 prescaler reset by stop", count_o, c + ((k >= 8) ? 1 : 0));
      step(1);
    end
  endtask

  task automatic t_autoreload();
    wr(3'd0, 32'd0);
    wr(3'd2, MAX - 32'd3);
    wr(3'd4, 32'd0);
    check("R6 trigger loads reload", count_o, MAX - 32'd3);
    wr(3'd0, C_RUN | C_AR);
    for (int k = 0; k <= 12; k++) begin
      check("R8 count with reload", count_o, MAX - 32'd3 + 32'(k % 4));
      check("R8 ovf pulse", {31'd0, ovf_o}, (k > 0 && k % 4 == 0) ? 1 : 0);
      step(1);
    end
  endtask

  task automatic t_oneshot();
    wr(3'd0, 32'd0);
    wr(3'd1, MAX - 32'd2);
    wr(3'd0, C_RUN);
    for (int k = 0; k <= 6; k++) begin
      check("R9 one-shot count", count_o, (k <= 2) ? MAX - 32'd2 + 32'(k) : 32'd0);
      check("R9 one-shot ovf", {31'd0, ovf_o}, (k == 3) ? 1 : 0);
      check("R9 one-shot run", {31'd0, run_o}, (k < 3) ? 1 : 0);
      step(1);
    end
  endtask

  task automatic t_match();
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd10);
    wr(3'd3, 32'd13);
    wr(3'd0, C_RUN | C_AR | C_CE);
    for (int k = 0; k <= 6; k++) begin
      check("R10 match pulse", {31'd0, match_o}, (k == 3) ? 1 : 0);
      step(1);
    end
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd10);
    wr(3'd0, C_RUN);
    for (int k = 0; k <= 6; k++) begin
      check("R10 no match without enable", {31'd0, match_o}, 0);
      step(1);
    end
    check("R10 counter passed compare", count_o, 17);
  endtask

  initial begin
    t_reset();
    t_load_and_count();
    t_prescale();
    t_presc_restart();
    t_stop();
    t_autoreload();
    t_oneshot();
    t_match();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule